// File: doc/BRIEF.md
# Combined Program/Character Bank Latch

This block is a cartridge bank mapper with a single write-only register. When the CPU stores a byte anywhere in the upper half of its address space, two bit fields of that byte are latched in the same clock edge. One field picks a 32 KB program bank that covers the whole upper half (0x8000 to 0xFFFF). The other picks an 8 KB character bank that covers the whole 13-bit video address range. Each field's bit position and width are parameters. Each selected bank number is reduced modulo the number of banks fitted, and that number is a power of two.

The mapper can optionally model a board on which the ROM still drives the data bus while the CPU writes. In that case the stored byte is the AND of the CPU's byte and the ROM byte at the write address, and the fields are taken from that result. The ROM read data must be presented on `rom_rdata` during the write cycle. The outputs are the extended ROM addresses: the registered bank number placed above the untranslated low address bits.

Top module: `bank_latch_mapper`

## Requirements
- R1: A synchronous active-low reset clears both bank numbers to 0. After reset, `prg_addr` equals `cpu_addr[14:0]` with zero upper bits, and `chr_addr` equals `ppu_addr` with zero upper bits.
- R2: `prg_addr` is the program bank number concatenated above `cpu_addr[14:0]`. `chr_addr` is the character bank number concatenated above `ppu_addr[12:0]`. Both follow address changes in the same cycle.
- R3: A write is `cpu_wr` high with `cpu_addr[15]` = 1. It updates both bank numbers at the same rising edge, and the new banks are visible on the outputs immediately after that edge.
- R4: The program field is PRG_FIELD_W bits starting at bit PRG_SHIFT of the stored byte. The character field is CHR_FIELD_W bits starting at bit CHR_SHIFT. With fields 5:4 and 1:0, writing 0x12 selects program bank 1 and character bank 2. With 4-bit fields at 7:4 and 3:0, writing 0x85 selects program bank 8 and character bank 5.
- R5: Each field value is reduced modulo its bank count (PRG_BANKS, CHR_BANKS). With 2 program banks, a field value of 2 gives bank 0 and a field value of 3 gives bank 1.
- R6: With CONFLICT_EN = 1, the stored byte is `cpu_data & rom_rdata`. For example, writing 0x13 over a ROM byte of 0x01 selects program bank 0 and character bank 1 for the default fields.
- R7: With CONFLICT_EN = 0, `rom_rdata` has no effect, and the stored byte is `cpu_data`.
- R8: Stores with `cpu_addr[15]` = 0 leave both banks unchanged. This includes program RAM addresses 0x6000 to 0x7FFF. Cycles with `cpu_wr` low also leave both banks unchanged.
- R9: Both bank numbers hold their values across any number of cycles without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one cycle per store |
| rom_rdata | input | 8 | Program ROM byte at `cpu_addr`, used when bus conflicts are modelled |
| ppu_addr | input | 13 | Video-side address into the character window |
| prg_addr | output | 15+log2(PRG_BANKS) | Extended program ROM address |
| chr_addr | output | 13+log2(CHR_BANKS) | Extended character ROM address |

## Verification
The hardest case to reach is one where the conflict AND changes the outcome. The ROM byte has to clear exactly the bits that the CPU byte sets, and only in the write cycle. The stimulus therefore drives `rom_rdata` as its own variable, separate from the address. Two instances see the same store at the same time: one models conflicts and one does not. So the same byte must produce different banks in the two instances, and the behavioural model has to predict both. Field wrap is reached by writing field values above the bank count of the narrow instance while the wide instance keeps them whole.

// File: rtl/bank_latch_pkg.sv
// Package: shared constants and types for the bank latch mapper.
// Assumes a byte-wide CPU data bus and a 16-bit CPU address whose top bit
// marks the ROM window.
package bank_latch_pkg;

    localparam int BYTE_W     = 8;
    localparam int CPU_AW     = 16;
    localparam int PPU_AW     = 13;
    localparam int PRG_OFS_W  = CPU_AW - 1;   // offset inside the 32 KB window

    // A qualified register store: whether it hit the ROM window and the
    // byte that actually reaches the latch.
    typedef struct packed {
        logic              hit;
        logic [BYTE_W-1:0] value;
    } latch_wr_t;

endpackage

// File: rtl/blm_write_decode.sv
// Module: blm_write_decode
// Qualifies a CPU store as a bank-register write, so that only strobes into
// the upper half of the address space count. When CONFLICT_EN is set, the
// latched byte is the AND of the CPU byte and the ROM byte.
// Assumes rom_rdata is the ROM content at cpu_addr during the write cycle.
module blm_write_decode
    import bank_latch_pkg::*;
#(
    parameter bit CONFLICT_EN = 1'b1
) (
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [BYTE_W-1:0] cpu_data,
    input  logic              cpu_wr,
    input  logic [BYTE_W-1:0] rom_rdata,
    output latch_wr_t         wr_req
);

    logic [BYTE_W-1:0] merged;

    // Choose the stored byte according to the bus model in use.
    generate
        if (CONFLICT_EN) begin : g_conflict
            always_comb merged = cpu_data & rom_rdata;
        end else begin : g_clean
            logic [BYTE_W-1:0] unused_rom;
            always_comb unused_rom = rom_rdata;
            always_comb merged = cpu_data;
        end
    endgenerate

    // Build the qualified request.
    always_comb begin
        wr_req.hit   = cpu_wr & cpu_addr[CPU_AW-1];
        wr_req.value = merged;
    end

endmodule

// File: rtl/blm_field_pick.sv
// Module: blm_field_pick
// Extracts FIELD_W bits starting at bit SHIFT of the stored byte and reduces
// the result modulo BANKS. The reduction is exact because BANKS is a power of
// two: the low log2(BANKS) bits are kept, and a narrower field is zero-extended.
// Assumes BANKS is a power of two of at least 2 and SHIFT+FIELD_W <= 8.
module blm_field_pick
    import bank_latch_pkg::*;
#(
    parameter int SHIFT   = 0,
    parameter int FIELD_W = 2,
    parameter int BANKS   = 4
) (
    input  logic [BYTE_W-1:0]        value,
    output logic [$clog2(BANKS)-1:0] bank
);

    localparam int BW = $clog2(BANKS);

    logic [BYTE_W-1:0]  shifted;
    logic [FIELD_W-1:0] field;

    // Align the field to bit 0 and keep only its width.
    always_comb begin
        shifted = value >> SHIFT;
        field   = shifted[FIELD_W-1:0];
    end

    // Wrap to the fitted bank count: truncate or zero-extend.
    generate
        if (FIELD_W >= BW) begin : g_trunc
            always_comb bank = field[BW-1:0];
        end else begin : g_extend
            always_comb bank = {{(BW-FIELD_W){1'b0}}, field};
        end
    endgenerate

endmodule

// File: rtl/blm_bank_reg.sv
// Module: blm_bank_reg
// A bank number register with synchronous active-low clear and load enable.
// Assumes load is only asserted for qualified writes.
module blm_bank_reg #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Hold the bank until reset or a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end

    // R1: reset clears the bank.
    p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> q == '0);

    // R3: a qualified write lands at the next edge.
    p_load_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> q == $past(d));

    // R9: no write, no change.
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));

endmodule

// File: rtl/bank_latch_mapper.sv
// Module: bank_latch_mapper (top)
// A single-register mapper. A store into 0x8000-0xFFFF latches a 32 KB
// program bank and an 8 KB character bank from two fields of one byte. The
// extended ROM addresses are the registered banks above the untranslated
// low address bits.
// Assumes PRG_BANKS and CHR_BANKS are powers of two of at least 2, and that
// rom_rdata holds the ROM byte at cpu_addr during a write.
module bank_latch_mapper
    import bank_latch_pkg::*;
#(
    parameter int PRG_SHIFT   = 4,
    parameter int PRG_FIELD_W = 2,
    parameter int CHR_SHIFT   = 0,
    parameter int CHR_FIELD_W = 2,
    parameter int PRG_BANKS   = 2,
    parameter int CHR_BANKS   = 4,
    parameter bit CONFLICT_EN = 1'b1,
    localparam int PRG_BW     = $clog2(PRG_BANKS),
    localparam int CHR_BW     = $clog2(CHR_BANKS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [CPU_AW-1:0]           cpu_addr,
    input  logic [BYTE_W-1:0]           cpu_data,
    input  logic                        cpu_wr,
    input  logic [BYTE_W-1:0]           rom_rdata,
    input  logic [PPU_AW-1:0]           ppu_addr,
    output logic [PRG_OFS_W+PRG_BW-1:0] prg_addr,
    output logic [PPU_AW+CHR_BW-1:0]    chr_addr
);

    latch_wr_t          wr_req;
    logic [PRG_BW-1:0]  prg_next;
    logic [CHR_BW-1:0]  chr_next;
    logic [PRG_BW-1:0]  prg_bank;
    logic [CHR_BW-1:0]  chr_bank;

    blm_write_decode #(
        .CONFLICT_EN (CONFLICT_EN)
    ) u_decode (
        .cpu_addr  (cpu_addr),
        .cpu_data  (cpu_data),
        .cpu_wr    (cpu_wr),
        .rom_rdata (rom_rdata),
        .wr_req    (wr_req)
    );

    blm_field_pick #(
        .SHIFT   (PRG_SHIFT),
        .FIELD_W (PRG_FIELD_W),
        .BANKS   (PRG_BANKS)
    ) u_prg_pick (
        .value (wr_req.value),
        .bank  (prg_next)
    );

    blm_field_pick #(
        .SHIFT   (CHR_SHIFT),
        .FIELD_W (CHR_FIELD_W),
        .BANKS   (CHR_BANKS)
    ) u_chr_pick (
        .value (wr_req.value),
        .bank  (chr_next)
    );

    blm_bank_reg #(.W(PRG_BW)) u_prg_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (wr_req.hit),
        .d     (prg_next),
        .q     (prg_bank)
    );

    blm_bank_reg #(.W(CHR_BW)) u_chr_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (wr_req.hit),
        .d     (chr_next),
        .q     (chr_bank)
    );

    // Compose the extended ROM addresses.
    always_comb begin
        prg_addr = {prg_bank, cpu_addr[PRG_OFS_W-1:0]};
        chr_addr = {chr_bank, ppu_addr};
    end

    // R8: stores below the ROM window leave both banks alone.
    p_low_store_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !cpu_addr[CPU_AW-1]) |=> $stable(prg_bank) && $stable(chr_bank));

    // R6: a store over a zero ROM byte can only select bank 0.
    generate
        if (CONFLICT_EN) begin : g_conflict_chk
            p_zero_rom_masks_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (cpu_wr && cpu_addr[CPU_AW-1] && rom_rdata == '0)
                |=> prg_bank == '0 && chr_bank == '0);
        end
    endgenerate

endmodule

// File: tb/sim_bank_latch_mapper.sv
module sim_bank_latch_mapper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic        cpu_wr = 1'b0;
    logic [7:0]  rom_rdata = 8'hFF;
    logic [12:0] ppu_addr = 13'h0000;
    logic [15:0] prg_addr0;
    logic [14:0] chr_addr0;
    logic [18:0] prg_addr1;
    logic [16:0] chr_addr1;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string tag = "R1";

    // Behavioural reference state: bank numbers of both instances.
    int m_prg0 = 0, m_chr0 = 0, m_prg1 = 0, m_chr1 = 0;

    always #5 clk = ~clk;

    // u0: conflicts on, 2-bit fields at 5:4 and 1:0, 2 program / 4 character banks.
    bank_latch_mapper u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_wr(cpu_wr), .rom_rdata(rom_rdata), .ppu_addr(ppu_addr),
        .prg_addr(prg_addr0), .chr_addr(chr_addr0));

    // u1: no conflicts, 4-bit fields at 7:4 and 3:0, 16 banks each.
    bank_latch_mapper #(
        .PRG_SHIFT(4), .PRG_FIELD_W(4), .CHR_SHIFT(0), .CHR_FIELD_W(4),
        .PRG_BANKS(16), .CHR_BANKS(16), .CONFLICT_EN(1'b0)
    ) u1 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_wr(cpu_wr), .rom_rdata(rom_rdata), .ppu_addr(ppu_addr),
        .prg_addr(prg_addr1), .chr_addr(chr_addr1));

    // Reference model: updates from the bench-driven inputs at each edge.
    always @(posedge clk) begin
        int e0, e1;
        if (!rst_n) begin
            m_prg0 = 0; m_chr0 = 0; m_prg1 = 0; m_chr1 = 0;
        end else if (cpu_wr && cpu_addr >= 16'h8000) begin
            e0 = int'(cpu_data & rom_rdata);
            e1 = int'(cpu_data);
            m_prg0 = ((e0 / 16) % 4) % 2;
            m_chr0 = (e0 % 4) % 4;
            m_prg1 = (e1 / 16) % 16;
            m_chr1 = e1 % 16;
        end
    end

    task automatic check_eq(input string t, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
        end
    endtask

    // Compare all outputs against the model.
    task automatic compare_all();
        int ofs = int'(cpu_addr) % 32768;
        check_eq(tag, "u0 prg_addr", int'(prg_addr0), m_prg0 * 32768 + ofs);
        check_eq(tag, "u0 chr_addr", int'(chr_addr0), m_chr0 * 8192 + int'(ppu_addr));
        check_eq(tag, "u1 prg_addr", int'(prg_addr1), m_prg1 * 32768 + ofs);
        check_eq(tag, "u1 chr_addr", int'(chr_addr1), m_chr1 * 8192 + int'(ppu_addr));
    endtask

    // One clock: the edge, then compare away from it.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        cycles++;
        compare_all();
    endtask

    task automatic store(input logic [15:0] a, input logic [7:0] d, input logic [7:0] r);
        cpu_addr = a; cpu_data = d; rom_rdata = r; cpu_wr = 1'b1;
        step();
        cpu_wr = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 200);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        tag = "R1";
        cpu_addr = 16'h8123; ppu_addr = 13'h0ABC;
        step(); step();
        rst_n = 1'b1;
        step();
        check_eq("R1", "u0 prg upper after reset", int'(prg_addr0[15]), 0);
        check_eq("R1", "u1 chr bank after reset", int'(chr_addr1[16:13]), 0);

        tag = "R2";
        cpu_addr = 16'hFFFF; ppu_addr = 13'h1FFF; step();
        cpu_addr = 16'h8000; ppu_addr = 13'h0000; step();

        tag = "R4";
        store(16'h8000, 8'h12, 8'hFF);
        check_eq("R4", "u0 prg bank for 0x12", int'(prg_addr0[15]), 1);
        check_eq("R4", "u0 chr bank for 0x12", int'(chr_addr0[14:13]), 2);
        store(16'h9000, 8'h85, 8'hFF);
        check_eq("R4", "u1 prg bank for 0x85", int'(prg_addr1[18:15]), 8);
        check_eq("R4", "u1 chr bank for 0x85", int'(chr_addr1[16:13]), 5);

        tag = "R5";
        store(16'hA000, 8'h20, 8'hFF);
        check_eq("R5", "u0 prg field 2 wraps", int'(prg_addr0[15]), 0);
        store(16'hA001, 8'h3B, 8'hFF);
        check_eq("R5", "u0 prg field 3 wraps", int'(prg_addr0[15]), 1);
        check_eq("R5", "u1 prg field 3 whole", int'(prg_addr1[18:15]), 3);

        tag = "R6";
        store(16'hC000, 8'h13, 8'h01);
        check_eq("R6", "u0 prg masked by rom", int'(prg_addr0[15]), 0);
        check_eq("R6", "u0 chr masked by rom", int'(chr_addr0[14:13]), 1);
        check_eq("R7", "u1 prg ignores rom", int'(prg_addr1[18:15]), 1);
        check_eq("R7", "u1 chr ignores rom", int'(chr_addr1[16:13]), 3);
        tag = "R7";
        store(16'hC001, 8'hF7, 8'h00);
        check_eq("R7", "u1 prg over zero rom", int'(prg_addr1[18:15]), 15);
        check_eq("R6", "u0 chr over zero rom", int'(chr_addr0[14:13]), 0);

        tag = "R8";
        store(16'h8000, 8'h12, 8'hFF);
        store(16'h7FFF, 8'hFF, 8'hFF);
        store(16'h6000, 8'h00, 8'hFF);
        check_eq("R8", "u0 prg after low stores", int'(prg_addr0[15]), 1);
        check_eq("R8", "u1 chr after low stores", int'(chr_addr1[16:13]), 2);
        cpu_addr = 16'h8000; cpu_data = 8'hFF; rom_rdata = 8'hFF; cpu_wr = 1'b0;
        step(); step();
        check_eq("R8", "u1 prg with strobe low", int'(prg_addr1[18:15]), 1);

        tag = "R9";
        for (int i = 0; i < 8; i++) begin
            cpu_addr = 16'h8000 + 16'(i * 4099); ppu_addr = 13'(i * 911);
            step();
        end

        tag = "R3";
        cpu_addr = 16'hFFFF; cpu_data = 8'h33; rom_rdata = 8'hFF; cpu_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        cpu_wr = 1'b0;
        check_eq("R3", "u0 prg one edge later", int'(prg_addr0[15]), 1);
        check_eq("R3", "u0 chr one edge later", int'(chr_addr0[14:13]), 3);
        check_eq("R3", "u1 prg one edge later", int'(prg_addr1[18:15]), 3);
        compare_all();
        step();

        tag = "R1";
        rst_n = 1'b0; step();
        rst_n = 1'b1; step();
        check_eq("R1", "u1 prg after second reset", int'(prg_addr1[18:15]), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule